// File: doc/BRIEF.md
# Power-Good Strap Latch and Clock Mode Decoder

This block sits at the front of a clock generator's control logic. At power-up, board straps set the CPU clock frequency, a test mode and the role of one shared differential output pair. The block samples these straps once, at the first moment an active-low power-good strobe is seen low. From the captured code it derives the selections that drive the divider network: the CPU and SRC clock settings, the reference-based divisors used in test mode, a tri-state request and a flag for an unsupported code.

Once the capture is done, the strobe pin takes a second role. It becomes an active-high power-down request that the block passes through as it changes. The capture is a one-shot event. The only exception is test mode, where the straps are sampled again on every cycle that the strobe is low, so a tester can move between test settings without a reset. All pins go through a synchronizer with a configurable number of stages. The reset input clears the captured state, so the power-up sequence can run again.

Top module: `strap_latch_decode`

## Requirements
- R1: Before the first capture, `sel_valid` is 0 and `hiz_req`, `test_mode`, `pwr_down`, `rsv_err` and `cpu2_route` are all 0, with `cpu_sel` and `src_sel` at 0 and all divisors at 0.
- R2: The first synchronized low on `pg_pin` captures the straps. The pin passes through SYNC_STAGES flops and is registered once more. `sel_valid` then stays 1, and `fs_latched` holds `{fs_c[1:0], fs_b, fs_a}`, where `fs_c` is encoded as 00 low, 01 mid, 10 high and 11 invalid.
- R3: Outside test mode, changes on `pg_pin`, `dbg_en`, `fs_c`, `fs_b` and `fs_a` that occur after capture leave `fs_latched` and `cpu2_route` unchanged.
- R4: After capture and outside test mode, `pwr_down` follows the synchronized `pg_pin` level, with 1 meaning power down. It is 0 before capture.
- R5: `dbg_en` is captured together with the straps. `cpu2_route` = 1 routes the shared pair as a CPU clock, and 0 routes it as SRC clock 7.
- R6: Code mid/0/1 gives `cpu_sel`=0 (100 MHz). Code low/0/1 gives `cpu_sel`=1 (133 MHz). Both codes give `src_sel`=0 (100 MHz) and all divisors 0.
- R7: With `fs_c` high and `fs_b`=0, the outputs are `test_mode`=1, `hiz_req`=1, `cpu_sel`=`src_sel`=3 (off) and all divisors 0.
- R8: With `fs_c` high and `fs_b`=1, the outputs are `test_mode`=1, `hiz_req`=0 and `cpu_sel`=`src_sel`=2 (reference-derived), with CPU, SRC and PCI divisors of 2, 8 and 24.
- R9: Every other code, including any code with `fs_c`=11, sets `rsv_err`=1 and falls back to `cpu_sel`=`src_sel`=0 with all divisors 0.
- R10: In test mode, the straps are captured again on every cycle where the synchronized pin is low, and `pwr_down` stays 0. A capture of a code that is not test mode locks the straps again.
- R11: Asserting `rst_n` low returns every output to the pre-capture state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pin | input | 1 | Power-good strobe (active low) before capture, power-down request (active high) after |
| dbg_en | input | 1 | Shared-pair routing strap |
| fs_c | input | 2 | Three-level select: 00 low, 01 mid, 10 high |
| fs_b | input | 1 | Frequency select strap B |
| fs_a | input | 1 | Frequency select strap A |
| sel_valid | output | 1 | Straps have been captured |
| fs_latched | output | 4 | Captured code {fs_c, fs_b, fs_a} |
| cpu_sel | output | 2 | CPU clock setting: 0 100 MHz, 1 133 MHz, 2 reference-derived, 3 off |
| src_sel | output | 2 | SRC clock setting, same encoding as cpu_sel |
| cpu_div | output | DIV_W | Reference divisor for CPU in test mode, else 0 |
| src_div | output | DIV_W | Reference divisor for SRC in test mode, else 0 |
| pci_div | output | DIV_W | Reference divisor for PCI in test mode, else 0 |
| hiz_req | output | 1 | Tri-state all clock outputs |
| test_mode | output | 1 | Test mode active |
| cpu2_route | output | 1 | 1 shared pair is CPU clock, 0 it is SRC clock 7 |
| pwr_down | output | 1 | Power-down request |
| rsv_err | output | 1 | Captured code is not supported |

## Verification
The bench builds the block with SYNC_STAGES=3, which is one stage more than the default, and with DIV_W=5. This checks that capture and power-down latency follow the parameter instead of a fixed depth. The bench's model delays the pins by the same parameter and is compared on every cycle. The stimulus walks all sixteen strap codes through a full reset-and-capture sequence. It also drives a test-mode session that switches from tri-state to reference mode, then locks into a normal code, and checks that power-down is suppressed and then restored.

// File: rtl/slpd_pkg.sv
package slpd_pkg;
   typedef enum logic [1:0] {
      CK_NOM  = 2'd0,
      CK_FAST = 2'd1,
      CK_REF  = 2'd2,
      CK_OFF  = 2'd3
   } ck_sel_e;

   typedef enum logic [1:0] {
      LV_LOW  = 2'd0,
      LV_MID  = 2'd1,
      LV_HIGH = 2'd2,
      LV_BAD  = 2'd3
   } lvl_e;

   // bit positions in the synchronized pin vector
   localparam int PIN_A   = 0;
   localparam int PIN_B   = 1;
   localparam int PIN_CLO = 2;
   localparam int PIN_CHI = 3;
   localparam int PIN_DBG = 4;
   localparam int PIN_PG  = 5;
   localparam int PINS_W  = 6;
   localparam int CODE_W  = 4;
endpackage

// File: rtl/slpd_sync.sv
module slpd_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("slpd_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/slpd_capture.sv
module slpd_capture
   import slpd_pkg::*;
#(
   parameter bit TEST_REARM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_s,
   input  logic              dbg_s,
   input  logic [CODE_W-1:0] code_s,
   output logic              captured,
   output logic [CODE_W-1:0] code_q,
   output logic              dbg_q,
   output logic              test_act,
   output logic              pd
);
   logic reopen;
   logic load;

   assign test_act = captured && (code_q[CODE_W-1 -: 2] == LV_HIGH);

   if (TEST_REARM) begin : g_rearm
      assign reopen = test_act;
   end else begin : g_oneshot
      assign reopen = 1'b0;
   end

   assign load = !pg_s && (!captured || reopen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured <= 1'b0;
         code_q   <= '0;
         dbg_q    <= 1'b0;
      end else if (load) begin
         captured <= 1'b1;
         code_q   <= code_s;
         dbg_q    <= dbg_s;
      end
   end

   assign pd = captured && pg_s && !test_act;
endmodule

// File: rtl/slpd_decode.sv
module slpd_decode
   import slpd_pkg::*;
#(
   parameter int DIV_W       = 5,
   parameter int CPU_REF_DIV = 2,
   parameter int SRC_REF_DIV = 8,
   parameter int PCI_REF_DIV = 24
) (
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   output ck_sel_e           cpu_sel,
   output ck_sel_e           src_sel,
   output logic [DIV_W-1:0]  cpu_div,
   output logic [DIV_W-1:0]  src_div,
   output logic [DIV_W-1:0]  pci_div,
   output logic              hiz,
   output logic              tmode,
   output logic              rsv
);
   localparam logic [DIV_W-1:0] CPU_D = DIV_W'(CPU_REF_DIV);
   localparam logic [DIV_W-1:0] SRC_D = DIV_W'(SRC_REF_DIV);
   localparam logic [DIV_W-1:0] PCI_D = DIV_W'(PCI_REF_DIV);

   always_comb begin
      cpu_sel = CK_NOM;
      src_sel = CK_NOM;
      cpu_div = '0;
      src_div = '0;
      pci_div = '0;
      hiz     = 1'b0;
      tmode   = 1'b0;
      rsv     = 1'b0;
      if (valid) begin
         casez (code)
            4'b0101: ;
            4'b0001: cpu_sel = CK_FAST;
            4'b100?: begin
               tmode   = 1'b1;
               hiz     = 1'b1;
               cpu_sel = CK_OFF;
               src_sel = CK_OFF;
            end
            4'b101?: begin
               tmode   = 1'b1;
               cpu_sel = CK_REF;
               src_sel = CK_REF;
               cpu_div = CPU_D;
               src_div = SRC_D;
               pci_div = PCI_D;
            end
            default: rsv = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/strap_latch_decode.sv
module strap_latch_decode
   import slpd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_W       = 5,
   parameter int CPU_REF_DIV = 2,
   parameter int SRC_REF_DIV = 8,
   parameter int PCI_REF_DIV = 24,
   parameter bit TEST_REARM  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pg_pin,
   input  logic             dbg_en,
   input  logic [1:0]       fs_c,
   input  logic             fs_b,
   input  logic             fs_a,
   output logic             sel_valid,
   output logic [3:0]       fs_latched,
   output logic [1:0]       cpu_sel,
   output logic [1:0]       src_sel,
   output logic [DIV_W-1:0] cpu_div,
   output logic [DIV_W-1:0] src_div,
   output logic [DIV_W-1:0] pci_div,
   output logic             hiz_req,
   output logic             test_mode,
   output logic             cpu2_route,
   output logic             pwr_down,
   output logic             rsv_err
);
   localparam logic [PINS_W-1:0] PIN_RST = PINS_W'(1) << PIN_PG;
   localparam int DIV_MAX = (1 << DIV_W) - 1;

   if (CPU_REF_DIV > DIV_MAX || SRC_REF_DIV > DIV_MAX || PCI_REF_DIV > DIV_MAX)
   begin : g_div_fit
      $error("strap_latch_decode: a reference divisor does not fit DIV_W");
   end

   logic [PINS_W-1:0] pins_raw, pins_s;
   logic [CODE_W-1:0] code_q;
   logic              captured, dbg_q, test_act, pd;
   logic              dec_tm;
   ck_sel_e           cpu_e, src_e;

   assign pins_raw = {pg_pin, dbg_en, fs_c, fs_b, fs_a};

   slpd_sync #(
      .W       (PINS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   slpd_capture #(
      .TEST_REARM (TEST_REARM)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .pg_s     (pins_s[PIN_PG]),
      .dbg_s    (pins_s[PIN_DBG]),
      .code_s   (pins_s[CODE_W-1:0]),
      .captured (captured),
      .code_q   (code_q),
      .dbg_q    (dbg_q),
      .test_act (test_act),
      .pd       (pd)
   );

   slpd_decode #(
      .DIV_W       (DIV_W),
      .CPU_REF_DIV (CPU_REF_DIV),
      .SRC_REF_DIV (SRC_REF_DIV),
      .PCI_REF_DIV (PCI_REF_DIV)
   ) u_dec (
      .valid   (captured),
      .code    (code_q),
      .cpu_sel (cpu_e),
      .src_sel (src_e),
      .cpu_div (cpu_div),
      .src_div (src_div),
      .pci_div (pci_div),
      .hiz     (hiz_req),
      .tmode   (dec_tm),
      .rsv     (rsv_err)
   );

   assign sel_valid  = captured;
   assign fs_latched = code_q;
   assign cpu_sel    = cpu_e;
   assign src_sel    = src_e;
   assign test_mode  = dec_tm && test_act;
   assign cpu2_route = dbg_q;
   assign pwr_down   = pd;
endmodule

// File: rtl/slpd_chk.sv
module slpd_chk #(
   parameter int DIV_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_valid,
   input logic [3:0]       fs_latched,
   input logic [1:0]       cpu_sel,
   input logic [1:0]       src_sel,
   input logic [DIV_W-1:0] cpu_div,
   input logic             hiz_req,
   input logic             test_mode,
   input logic             cpu2_route,
   input logic             pwr_down,
   input logic             rsv_err
);
   p_quiet_before_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> (!hiz_req && !test_mode && !pwr_down && !rsv_err && !cpu2_route));

   p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |=> sel_valid);

   p_locked_straps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !test_mode) |=> ($stable(fs_latched) && $stable(cpu2_route)));

   p_pd_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> sel_valid);

   p_hiz_outputs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_req |-> (test_mode && cpu_sel == 2'd3 && src_sel == 2'd3));

   p_ref_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !hiz_req) |-> (cpu_sel == 2'd2 && src_sel == 2'd2 && cpu_div != '0));

   p_reserved_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_err |-> (cpu_sel == 2'd0 && src_sel == 2'd0 && !test_mode));

   p_test_no_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> !pwr_down);
endmodule

bind strap_latch_decode slpd_chk #(.DIV_W(DIV_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_valid  (sel_valid),
   .fs_latched (fs_latched),
   .cpu_sel    (cpu_sel),
   .src_sel    (src_sel),
   .cpu_div    (cpu_div),
   .hiz_req    (hiz_req),
   .test_mode  (test_mode),
   .cpu2_route (cpu2_route),
   .pwr_down   (pwr_down),
   .rsv_err    (rsv_err)
);

// File: tb/strap_latch_decode_tb.sv
module strap_latch_decode_tb;
   localparam int S  = 3;
   localparam int DW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pg_pin = 1'b1, dbg_en = 1'b0, fs_b = 1'b0, fs_a = 1'b0;
   logic [1:0] fs_c = 2'b00;

   logic sel_valid, hiz_req, test_mode, cpu2_route, pwr_down, rsv_err;
   logic [3:0] fs_latched;
   logic [1:0] cpu_sel, src_sel;
   logic [DW-1:0] cpu_div, src_div, pci_div;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   strap_latch_decode #(.SYNC_STAGES(S), .DIV_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pg_pin(pg_pin), .dbg_en(dbg_en),
      .fs_c(fs_c), .fs_b(fs_b), .fs_a(fs_a),
      .sel_valid(sel_valid), .fs_latched(fs_latched),
      .cpu_sel(cpu_sel), .src_sel(src_sel),
      .cpu_div(cpu_div), .src_div(src_div), .pci_div(pci_div),
      .hiz_req(hiz_req), .test_mode(test_mode), .cpu2_route(cpu2_route),
      .pwr_down(pwr_down), .rsv_err(rsv_err)
   );

   // reference model: pin history (index 0 newest), captured state
   int hist [S];
   bit m_cap;
   int m_code;
   bit m_dbg;

   function automatic bit m_test();
      return m_cap && ((m_code >> 2) == 2);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < S; i++) hist[i] = 32;
         m_cap = 0; m_code = 0; m_dbg = 0;
      end else begin
         int old;
         old = hist[S-1];
         if (((old >> 5) & 1) == 0 && (!m_cap || m_test())) begin
            m_cap = 1; m_code = old & 15; m_dbg = ((old >> 4) & 1) != 0;
         end
         for (int i = S-1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = (int'(pg_pin) << 5) | (int'(dbg_en) << 4) | (int'(fs_c) << 2)
                   | (int'(fs_b) << 1) | int'(fs_a);
      end
   end

   // expected decode of a captured code from the requirement tables
   task automatic exp_decode(input bit valid, input int code,
                             output int cs, output int ss, output int cd, output int sd,
                             output int pd, output bit hz, output bit tm, output bit rv,
                             output string tag);
      int c; int b; int a;
      c = code >> 2; b = (code >> 1) & 1; a = code & 1;
      cs = 0; ss = 0; cd = 0; sd = 0; pd = 0; hz = 0; tm = 0; rv = 0; tag = "R1";
      if (valid) begin
         if (c == 1 && b == 0 && a == 1) tag = "R6";
         else if (c == 0 && b == 0 && a == 1) begin cs = 1; tag = "R6"; end
         else if (c == 2 && b == 0) begin tm = 1; hz = 1; cs = 3; ss = 3; tag = "R7"; end
         else if (c == 2 && b == 1) begin
            tm = 1; cs = 2; ss = 2; cd = 2; sd = 8; pd = 24; tag = "R8";
         end else begin rv = 1; tag = "R9"; end
      end
   endtask

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && rst_n && !done) begin
         int cs, ss, cd, sd, pd; bit hz, tm, rv; string tag;
         exp_decode(m_cap, m_code, cs, ss, cd, sd, pd, hz, tm, rv, tag);
         chk("R2", "sel_valid", int'(sel_valid), int'(m_cap));
         chk("R3", "fs_latched", int'(fs_latched), m_code);
         chk("R5", "cpu2_route", int'(cpu2_route), int'(m_dbg));
         chk("R4", "pwr_down", int'(pwr_down),
             int'(m_cap && ((hist[S-1] >> 5) & 1) == 1 && !m_test()));
         chk(tag, "cpu_sel", int'(cpu_sel), cs);
         chk(tag, "src_sel", int'(src_sel), ss);
         chk(tag, "cpu_div", int'(cpu_div), cd);
         chk(tag, "src_div", int'(src_div), sd);
         chk(tag, "pci_div", int'(pci_div), pd);
         chk(tag, "hiz_req", int'(hiz_req), int'(hz));
         chk(tag, "test_mode", int'(test_mode), int'(tm));
         chk(tag, "rsv_err", int'(rsv_err), int'(rv));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input bit pg, input bit dbg, input int c, input bit b, input bit a);
      @(negedge clk);
      pg_pin = pg; dbg_en = dbg; fs_c = 2'(c); fs_b = b; fs_a = a;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pg_pin = 1'b1;
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
   end

   initial begin
      // R1: reset and idle before capture
      cyc(3);
      rst_n = 1'b1;
      @(posedge clk);
      mon_on = 1'b1;
      drive(1, 0, 1, 0, 1);
      cyc(8);
      chk("R1", "sel_valid idle", int'(sel_valid), 0);
      chk("R1", "pwr_down idle", int'(pwr_down), 0);

      // R2/R6: capture mid/0/1 -> 100 MHz, exact latency S+1
      drive(0, 0, 1, 0, 1);
      cyc(S);
      chk("R2", "not yet captured", int'(sel_valid), 0);
      cyc(1);
      chk("R2", "captured", int'(sel_valid), 1);
      chk("R6", "cpu 100", int'(cpu_sel), 0);

      // R3/R4: straps change then pin high -> power down, code locked
      drive(0, 1, 0, 1, 0);
      cyc(6);
      chk("R3", "code locked", int'(fs_latched), 4'b0101);
      drive(1, 1, 0, 1, 0);
      cyc(S);
      chk("R4", "pd on", int'(pwr_down), 1);
      drive(0, 1, 0, 1, 0);
      cyc(S + 2);
      chk("R4", "pd off", int'(pwr_down), 0);
      chk("R3", "still locked", int'(fs_latched), 4'b0101);

      // R11 and R5/R6: reset then low/0/1 with debug route
      do_reset();
      cyc(1);
      chk("R11", "cleared", int'(sel_valid), 0);
      chk("R11", "route cleared", int'(cpu2_route), 0);
      drive(0, 1, 0, 0, 1);
      cyc(S + 3);
      chk("R5", "route cpu", int'(cpu2_route), 1);
      chk("R6", "cpu 133", int'(cpu_sel), 1);

      // R7 -> R8 -> relock (R10)
      do_reset();
      drive(0, 0, 2, 0, 0);
      cyc(S + 3);
      chk("R7", "hiz", int'(hiz_req), 1);
      drive(1, 0, 2, 0, 0);
      cyc(S + 2);
      chk("R10", "no pd in test", int'(pwr_down), 0);
      drive(0, 0, 2, 1, 0);
      cyc(S + 3);
      chk("R8", "ref mode", int'(cpu_sel), 2);
      chk("R8", "pci div", int'(pci_div), 24);
      chk("R10", "resampled", int'(fs_latched), 4'b1010);
      drive(0, 1, 1, 0, 1);
      cyc(S + 3);
      chk("R10", "relocked normal", int'(test_mode), 0);
      drive(0, 0, 0, 0, 1);
      cyc(S + 3);
      chk("R10", "locked again", int'(fs_latched), 4'b0101);
      drive(1, 0, 0, 0, 1);
      cyc(S + 1);
      chk("R4", "pd after relock", int'(pwr_down), 1);

      // R9: walk every code
      for (int code = 0; code < 16; code++) begin
         bit rsv_exp;
         rsv_exp = !(code == 5 || code == 1 || (code >> 2) == 2);
         do_reset();
         drive(0, 0, code >> 2, (code >> 1) & 1, code & 1);
         cyc(S + 3);
         chk(rsv_exp ? "R9" : "R2", "reserved flag", int'(rsv_err), int'(rsv_exp));
      end

      cyc(4);
      summary();
   end
endmodule